// File: doc/BRIEF.md
# Switchable-Pair Frequency Synthesiser Core

This block is the digital heart of a phase-locked frequency synthesiser. A reference divider counts crystal-clock strobes and emits one reference edge every M strobes. A feedback path counts VCO-clock strobes through a fixed divide-by-16 prescaler and then a programmable divide-by-N counter, so the loop settles at f_out = 16 · N · f_ref / M (for example M = 257, N = 697 with a 10 MHz crystal gives roughly 433.93 MHz). A two-flip-flop phase-frequency detector compares the two divided edges and produces pump-up and pump-down pulses for an external charge pump and loop filter.

Two divider pairs, pair 0 (N0, M0) and pair 1 (N1, M1), arrive in parallel from a control register. Slow FSK is produced by switching pairs from a data line: only while transmitting in modulation mode 01 does the data bit pick the pair; every other mode, and receive, uses pair 0. A new pair is adopted by each counter only at its own terminal count, so no shortened divider cycle is produced. A lock flag reports a run of tight comparisons, and a power-down input freezes the whole core.

Both clock domains are represented by single-cycle enable strobes (ref_en, vco_en) sampled on one core clock.

Top module: `fsk_synth_core`

## Requirements
- R1: While rst_n is low all outputs (pump_up, pump_dn, locked, ref_tick, fb_tick) are 0.
- R2: With pair M value m (1..1023), ref_tick pulses for one core cycle on every m-th ref_en strobe; a value of 0 divides by 1024.
- R3: With pair N value n (1..4095), fb_tick pulses for one core cycle on every (16 · n)-th vco_en strobe.
- R4: When tx_mode = 1 and mod_mode = 2'b01, fsk_data = 0 selects pair 0 (n0, m0) and fsk_data = 1 selects pair 1 (n1, m1).
- R5: In mod_mode 2'b00, 2'b10 and 2'b11 pair 0 is used whatever fsk_data is.
- R6: In receive (tx_mode = 0) pair 0 is used whatever mod_mode and fsk_data are.
- R7: A change of selected pair takes effect in each counter only after its current division cycle ends; the cycle in progress keeps its old length.
- R8: A reference edge arriving first raises pump_up in the next cycle; a feedback edge arriving first raises pump_dn; the second edge clears both, so pump_up and pump_dn are never high together, and coincident edges raise neither.
- R9: locked rises once 16 consecutive comparisons have completed, each with a pump pulse that spanned at most one ref_en strobe.
- R10: A comparison whose pump pulse spans two or more ref_en strobes drops locked and restarts the count.
- R11: While pwr_dn is high both counters and the detector are held cleared: from the next cycle pump_up, pump_dn and locked are 0, and ref_tick and fb_tick stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down hold, synchronous |
| ref_en | input | 1 | One crystal-clock strobe |
| vco_en | input | 1 | One VCO-clock strobe |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| mod_mode | input | 2 | Modulation mode; 01 = pair switching |
| fsk_data | input | 1 | FSK data bit used for pair switching |
| n0 | input | 12 | Feedback divider, pair 0 |
| m0 | input | 10 | Reference divider, pair 0 |
| n1 | input | 12 | Feedback divider, pair 1 |
| m1 | input | 10 | Reference divider, pair 1 |
| ref_tick | output | 1 | Divided reference edge |
| fb_tick | output | 1 | Divided feedback edge |
| pump_up | output | 1 | Charge-pump up request |
| pump_dn | output | 1 | Charge-pump down request |
| locked | output | 1 | Lock indicator |

## Verification
The reference edge and the feedback edge can land in the same core cycle, and the detector must then treat it as a finished, perfectly aligned comparison rather than set either pump. The bench provokes this by choosing M = 16 and N = 1 with both strobes running every cycle, so after power-down release the two counters reach terminal count together on every period; it requires that neither pump ever rises and that locked rises exactly after the sixteenth coincident tick. It then switches to a pair with M = 20 mid-run, so the next feedback edge leads by four cycles, and judges that pump_dn appears and locked falls.

// File: rtl/fsk_synth_core.sv
`timescale 1ns/1ps
module fsk_synth_core #(
  parameter int NW     = 12,
  parameter int MW     = 10,
  parameter int PRE    = 16,
  parameter int LOCK_N = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_dn,
  input  logic          ref_en,
  input  logic          vco_en,
  input  logic          tx_mode,
  input  logic [1:0]    mod_mode,
  input  logic          fsk_data,
  input  logic [NW-1:0] n0,
  input  logic [MW-1:0] m0,
  input  logic [NW-1:0] n1,
  input  logic [MW-1:0] m1,
  output logic          ref_tick,
  output logic          fb_tick,
  output logic          pump_up,
  output logic          pump_dn,
  output logic          locked
);
  localparam int PW = $clog2(PRE);
  localparam int LW = $clog2(LOCK_N + 1);
  localparam logic [MW-1:0] M_ONE   = MW'(1);
  localparam logic [NW-1:0] N_ONE   = NW'(1);
  localparam logic [PW-1:0] PRE_TOP = PW'(PRE - 1);
  localparam logic [LW-1:0] LK_TOP  = LW'(LOCK_N);

  logic [MW-1:0] m_act, rcnt;
  logic [NW-1:0] n_act, ncnt;
  logic [PW-1:0] pcnt;
  logic [1:0]    wcnt;
  logic [LW-1:0] lcnt;
  logic          up_q, dn_q;

  wire use_p1 = tx_mode && (mod_mode == 2'b01) && fsk_data;
  wire [NW-1:0] n_sel = use_p1 ? n1 : n0;
  wire [MW-1:0] m_sel = use_p1 ? m1 : m0;

  wire pre_tc = !pwr_dn && vco_en && (pcnt == PRE_TOP);
  assign ref_tick = !pwr_dn && ref_en && (rcnt == m_act - M_ONE);
  assign fb_tick  = pre_tc && (ncnt == n_act - N_ONE);

  wire pend_up  = up_q || ref_tick;
  wire pend_dn  = dn_q || fb_tick;
  wire cmp_done = pend_up && pend_dn;
  wire strobe_in = ref_en && (up_q || dn_q);
  wire wide     = wcnt[1] || (wcnt != 2'd0 && strobe_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= '0; n_act <= '0;
      rcnt  <= '0; ncnt  <= '0; pcnt <= '0;
    end else if (pwr_dn) begin
      m_act <= m_sel; n_act <= n_sel;
      rcnt  <= '0; ncnt  <= '0; pcnt <= '0;
    end else begin
      if (ref_tick) begin
        rcnt  <= '0;
        m_act <= m_sel;
      end else if (ref_en) begin
        rcnt <= rcnt + M_ONE;
      end
      if (vco_en) pcnt <= pcnt + PW'(1);
      if (fb_tick) begin
        ncnt  <= '0;
        n_act <= n_sel;
      end else if (pre_tc) begin
        ncnt <= ncnt + N_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0; dn_q <= 1'b0; wcnt <= '0; lcnt <= '0;
    end else if (pwr_dn) begin
      up_q <= 1'b0; dn_q <= 1'b0; wcnt <= '0; lcnt <= '0;
    end else begin
      up_q <= pend_up && !cmp_done;
      dn_q <= pend_dn && !cmp_done;
      if (cmp_done)                 wcnt <= '0;
      else if (strobe_in && !wcnt[1]) wcnt <= wcnt + 2'd1;
      if (cmp_done) begin
        if (wide)                 lcnt <= '0;
        else if (lcnt != LK_TOP)  lcnt <= lcnt + LW'(1);
      end
    end
  end

  assign pump_up = up_q;
  assign pump_dn = dn_q;
  assign locked  = (lcnt == LK_TOP);
endmodule

// File: rtl/fsk_synth_core_chk.sv
`timescale 1ns/1ps
module fsk_synth_core_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_dn,
  input logic ref_en,
  input logic vco_en,
  input logic ref_tick,
  input logic fb_tick,
  input logic pump_up,
  input logic pump_dn,
  input logic locked
);
  a_r11_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!pump_up && !pump_dn && !locked));
  a_r11_pd_no_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (!ref_tick && !fb_tick));
  a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));
  a_r8_up_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && !fb_tick && !pump_dn) |=> pump_up);
  a_r8_dn_on_fb: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_tick && !ref_tick && !pump_up) |=> pump_dn);
  a_r2_ref_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |-> ref_en);
  a_r3_fb_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    fb_tick |-> vco_en);
endmodule

bind fsk_synth_core fsk_synth_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .ref_en(ref_en), .vco_en(vco_en),
  .ref_tick(ref_tick), .fb_tick(fb_tick), .pump_up(pump_up), .pump_dn(pump_dn),
  .locked(locked)
);

// File: tb/fsk_synth_core_tb.sv
`timescale 1ns/1ps
module fsk_synth_core_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, pwr_dn = 1'b0, ref_en = 1'b1, vco_en = 1'b1;
  logic tx_mode = 1'b0, fsk_data = 1'b0;
  logic [1:0] mod_mode = 2'b00;
  logic [11:0] n0 = 12'd1, n1 = 12'd1;
  logic [9:0]  m0 = 10'd1, m1 = 10'd1;
  logic ref_tick, fb_tick, pump_up, pump_dn, locked;

  int checks = 0, errors = 0;

  fsk_synth_core u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .ref_en(ref_en), .vco_en(vco_en),
    .tx_mode(tx_mode), .mod_mode(mod_mode), .fsk_data(fsk_data),
    .n0(n0), .m0(m0), .n1(n1), .m1(m1),
    .ref_tick(ref_tick), .fb_tick(fb_tick), .pump_up(pump_up), .pump_dn(pump_dn),
    .locked(locked)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setcfg(input int a, input int b, input int c, input int d,
                        input bit tx, input logic [1:0] md, input bit dat);
    n0 = 12'(a); m0 = 10'(b); n1 = 12'(c); m1 = 10'(d);
    tx_mode = tx; mod_mode = md; fsk_data = dat;
  endtask

  task automatic restart;
    @(negedge clk) pwr_dn = 1'b1;
    repeat (2) @(negedge clk);
    pwr_dn = 1'b0;
  endtask

  function automatic bit tk(input bit fb);
    return fb ? fb_tick : ref_tick;
  endfunction

  task automatic wait_tick(input bit fb);
    int g = 0;
    do begin @(negedge clk); g++; end while (!tk(fb) && g < 20000);
  endtask

  task automatic measure(input bit fb, output int per);
    wait_tick(fb);
    per = 0;
    do begin @(negedge clk); per++; end while (!tk(fb) && per < 20000);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p, k, cnt;
    bit just, seen_dn, bad;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!pump_up && !pump_dn && !locked && !ref_tick && !fb_tick, "R1 reset outputs", 
        int'({pump_up, pump_dn, locked, ref_tick, fb_tick}), 0);
    rst_n = 1'b1;

    // R2 / R3: sweep of divider values on pair 0
    for (int m = 1; m <= 6; m++) begin
      for (int n = 1; n <= 3; n++) begin
        setcfg(n, m, 4, 9, 1'b0, 2'b00, 1'b0);
        restart();
        measure(1'b0, p); chk(p == m, "R2 ref period", p, m);
        measure(1'b1, p); chk(p == 16 * n, "R3 fb period", p, 16 * n);
      end
    end

    // R4: pair switching in mode 01 while transmitting
    setcfg(2, 5, 3, 7, 1'b1, 2'b01, 1'b1);
    restart();
    measure(1'b0, p); chk(p == 7, "R4 data1 ref", p, 7);
    measure(1'b1, p); chk(p == 48, "R4 data1 fb", p, 48);
    setcfg(2, 5, 3, 7, 1'b1, 2'b01, 1'b0);
    restart();
    measure(1'b0, p); chk(p == 5, "R4 data0 ref", p, 5);
    measure(1'b1, p); chk(p == 32, "R4 data0 fb", p, 32);

    // R5: other modes ignore data
    for (int md = 0; md < 4; md++) begin
      if (md == 1) continue;
      setcfg(2, 5, 3, 7, 1'b1, 2'(md), 1'b1);
      restart();
      measure(1'b0, p); chk(p == 5, "R5 mode ref", p, 5);
      measure(1'b1, p); chk(p == 32, "R5 mode fb", p, 32);
    end

    // R6: receive ignores mode and data
    setcfg(2, 5, 3, 7, 1'b0, 2'b01, 1'b1);
    restart();
    measure(1'b0, p); chk(p == 5, "R6 receive ref", p, 5);
    measure(1'b1, p); chk(p == 32, "R6 receive fb", p, 32);

    // R7: switch only at terminal count
    setcfg(1, 5, 1, 3, 1'b1, 2'b01, 1'b0);
    restart();
    wait_tick(1'b0);
    cnt = 0;
    do begin
      @(negedge clk); cnt++;
      if (cnt == 2) fsk_data = 1'b1;
    end while (!ref_tick && cnt < 100);
    chk(cnt == 5, "R7 current cycle kept", cnt, 5);
    measure(1'b0, p); chk(p == 3, "R7 new pair next cycle", p, 3);

    // R8: direction of the first pump pulse
    setcfg(1, 12, 1, 1, 1'b0, 2'b00, 1'b0);
    restart();
    k = 0;
    do begin @(negedge clk); k++; end while (!pump_up && !pump_dn && k < 200);
    chk(pump_up && !pump_dn, "R8 ref first gives up", int'({pump_up, pump_dn}), 2);
    setcfg(1, 20, 1, 1, 1'b0, 2'b00, 1'b0);
    restart();
    k = 0;
    do begin @(negedge clk); k++; end while (!pump_up && !pump_dn && k < 200);
    chk(!pump_up && pump_dn, "R8 fb first gives down", int'({pump_up, pump_dn}), 1);

    // R8 / R9: coincident edges, lock after 16 comparisons
    setcfg(1, 16, 1, 20, 1'b1, 2'b01, 1'b0);
    restart();
    k = 0; just = 0; bad = 0;
    for (int c = 0; c < 400 && k < 17; c++) begin
      @(negedge clk);
      if (just && k == 15) chk(!locked, "R9 not locked after 15", locked, 0);
      if (just && k == 16) chk(locked, "R9 locked after 16", locked, 1);
      if (pump_up || pump_dn) bad = 1;
      just = ref_tick;
      if (ref_tick) k++;
    end
    chk(!bad, "R8 coincident edges raise no pump", bad, 0);

    // R10: wide comparison drops lock
    fsk_data = 1'b1;
    seen_dn = 0;
    k = 0;
    do begin
      @(negedge clk); k++;
      if (pump_dn) seen_dn = 1;
    end while (locked && k < 100);
    chk(seen_dn, "R10 down pulse seen", seen_dn, 1);
    chk(!locked, "R10 lock dropped", locked, 0);

    // R11: power down
    fsk_data = 1'b0;
    restart();
    k = 0;
    do begin @(negedge clk); k++; end while (!locked && k < 600);
    chk(locked, "R11 relocked before power down", locked, 1);
    pwr_dn = 1'b1;
    bad = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (pump_up || pump_dn || locked || ref_tick || fb_tick) bad = 1;
    end
    chk(!bad, "R11 outputs held during power down", bad, 0);
    pwr_dn = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule